// File: doc/BRIEF.md
# Random Word Readiness Sequencer

This block paces a random number source. It decides the clock cycle in which the next random word counts as ready and raises a one-cycle `num_valid` pulse in that cycle. A down-counter stands for the generation latency. The latency depends on the entropy mode. With `export_mode` high (exported entropy) a word takes `LAT_EXPORT` = 80 cycles. With `export_mode` low (native) it takes `LAT_NATIVE` = 730 cycles. The same block also picks one byte of a wide entropy vector as the byte fed to the storage FIFO.

The host drives four control bits:
- `ent_on` enables the entropy source.
- `out_on` lets generated words be delivered.
- `export_mode` selects the latency.
- `gen_hold` is a generator reset that the host must clear itself.

A 4-bit `slice_sel` chooses the byte.

The control is a three-state machine:
- **HOLD**: `gen_hold` is high, or the block has just left reset. No count runs.
- **COUNT**: the counter runs, pauses or restarts.
- **FIRE**: the one cycle in which `num_valid` is high.

Transitions:
- HOLD→COUNT happens on the first edge that samples `gen_hold` low. That edge loads the latency of the current mode.
- COUNT→FIRE happens on the edge that finds the counter at zero with `ent_on` and `out_on` high. The same edge reloads the counter.
- FIRE→COUNT happens on the next edge, which already counts down.
- COUNT→COUNT on a zero count with `out_on` low reloads the counter without a pulse.
- COUNT/FIRE→HOLD happens whenever `gen_hold` is sampled high.
- A change of `export_mode` seen in COUNT or FIRE reloads the counter and goes to COUNT.

Top module: `rng_ready_seq`

## Requirements
- R1: While `rst_n` is low, `num_valid` is 0. After reset the block sits in HOLD. With `gen_hold` low, the first clock edge after `rst_n` rises acts as a release edge.
- R2: While `gen_hold` is sampled high, any count in progress is discarded and `num_valid` stays 0 for as long as the host keeps `gen_hold` high. Nothing inside the block clears it.
- R3: Call the first edge that samples `gen_hold` low (the release edge) E0. `num_valid` is high in the cycle that follows edge E0+730 when `export_mode` is 0, and edge E0+80 when `export_mode` is 1.
- R4: A change of `export_mode` sampled while counting discards the count, with no pulse, and the switch edge acts as a release edge. A 0→1 switch gives the next pulse 80 edges later. A 1→0 switch gives it 730 edges later.
- R5: `num_valid` is high for exactly one cycle. The pulse edge reloads the counter, so with steady inputs the pulses repeat every 80 (export) or 730 (native) edges.
- R6: While `ent_on` is sampled low, the counter holds its value and no pulse occurs. Counting resumes from the held value once `ent_on` returns high.
- R7: While `out_on` is sampled low, no pulse occurs, but counting and reloading go on unchanged. The pulse schedule therefore keeps its phase when `out_on` returns high.
- R8: `fifo_byte` combinationally equals `entropy_vec[8k+7:8k]`, where k is the unsigned value of `slice_sel` (0 to 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_on | input | 1 | Entropy enable; low pauses the count |
| out_on | input | 1 | Output enable; low suppresses pulses |
| export_mode | input | 1 | 1 = exported entropy (80 cycles), 0 = native (730 cycles) |
| gen_hold | input | 1 | Generator reset, held by the host until it clears it |
| slice_sel | input | 4 | Byte index into the entropy vector |
| entropy_vec | input | 128 | Raw entropy bits |
| fifo_byte | output | 8 | Selected byte for the FIFO input |
| num_valid | output | 1 | One-cycle pulse: next random word ready |

## Verification
The bench measures the exact edge count from each release, mode switch and resume to the pulse. A design that loaded the count one cycle late, or forgot the reload, would be off by one or would stop pulsing.

- Hold is asserted with 230 cycles still left in a native count and kept well past that point. A design that let the old count finish would pulse during the hold.
- `export_mode` is switched in both directions in the middle of a count. A design that kept the stale count, or used the old latency, would pulse at the wrong edge.
- `ent_on` is dropped mid-count. A design that reloaded the counter on resume, instead of holding it, would come out 40 edges late.
- `out_on` is dropped across two would-be pulses. A design that reset its phase on the gate would miss the expected edge.

// File: rtl/rng_seq_pkg.sv
package rng_seq_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/rng_lat_counter.sv
module rng_lat_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);

    // R5: the sequencer never asks for a decrement below zero
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

endmodule

// File: rtl/rng_slice_mux.sv
module rng_slice_mux #(
    parameter int VEC_W   = 128,
    parameter int SLICE_W = 8,
    localparam int N_SLICE = VEC_W / SLICE_W,
    localparam int SEL_W   = $clog2(N_SLICE)
) (
    input  logic [VEC_W-1:0]   vec,
    input  logic [SEL_W-1:0]   sel,
    output logic [SLICE_W-1:0] slice
);

    logic [SLICE_W-1:0] parts [N_SLICE];

    for (genvar g = 0; g < N_SLICE; g++) begin : g_part
        assign parts[g] = vec[g*SLICE_W +: SLICE_W];
    end

    assign slice = parts[sel];

endmodule

// File: rtl/rng_ready_seq.sv
module rng_ready_seq
    import rng_seq_pkg::*;
#(
    parameter int LAT_EXPORT = 80,
    parameter int LAT_NATIVE = 730,
    parameter int VEC_W      = 128,
    parameter int SLICE_W    = 8,
    localparam int SEL_W     = $clog2(VEC_W / SLICE_W),
    localparam int LAT_MAX   = (LAT_NATIVE > LAT_EXPORT) ? LAT_NATIVE : LAT_EXPORT,
    localparam int CNT_W     = $clog2(LAT_MAX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ent_on,
    input  logic               out_on,
    input  logic               export_mode,
    input  logic               gen_hold,
    input  logic [SEL_W-1:0]   slice_sel,
    input  logic [VEC_W-1:0]   entropy_vec,
    output logic [SLICE_W-1:0] fifo_byte,
    output logic               num_valid
);

    localparam logic [CNT_W-1:0] RELOAD_EXP = CNT_W'(LAT_EXPORT - 1);
    localparam logic [CNT_W-1:0] RELOAD_NAT = CNT_W'(LAT_NATIVE - 1);

    seq_state_e       state_q, state_d;
    logic             mode_q;
    logic             mode_chg;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val, reload_val;

    assign mode_chg   = (export_mode != mode_q);
    assign reload_val = export_mode ? RELOAD_EXP : RELOAD_NAT;

    // State register and last-seen mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= export_mode;
        end
    end

    // Next state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (!gen_hold) begin
                    cnt_load = 1'b1;
                    state_d  = ST_COUNT;
                end
            end
            ST_COUNT, ST_FIRE: begin
                if (gen_hold) begin
                    state_d = ST_HOLD;
                end else if (mode_chg) begin
                    cnt_load = 1'b1;
                    state_d  = ST_COUNT;
                end else if (!ent_on) begin
                    state_d = ST_COUNT;
                end else if (cnt_zero) begin
                    cnt_load = 1'b1;
                    state_d  = out_on ? ST_FIRE : ST_COUNT;
                end else begin
                    cnt_dec = 1'b1;
                    state_d = ST_COUNT;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // Moore output
    always_comb begin
        num_valid = (state_q == ST_FIRE);
    end

    rng_lat_counter #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (reload_val),
        .dec      (cnt_dec),
        .cnt      (cnt_val),
        .zero     (cnt_zero)
    );

    rng_slice_mux #(
        .VEC_W   (VEC_W),
        .SLICE_W (SLICE_W)
    ) i_mux (
        .vec   (entropy_vec),
        .sel   (slice_sel),
        .slice (fifo_byte)
    );

    a_r2_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        gen_hold |=> !num_valid);

    a_r4_switch_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !num_valid);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        num_valid |=> !num_valid);

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_val <= RELOAD_NAT || cnt_val <= RELOAD_EXP);

    a_r6_pause_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !ent_on |=> !num_valid);

    a_r7_gate_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !out_on |=> !num_valid);

endmodule

// File: tb/test_rng_ready_seq.sv
`timescale 1ns/1ps
module test_rng_ready_seq;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ent_on, out_on, export_mode, gen_hold;
    logic [3:0]   slice_sel;
    logic [127:0] entropy_vec;
    logic [7:0]   fifo_byte;
    logic         num_valid;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    rng_ready_seq i_rng_ready_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ent_on      (ent_on),
        .out_on      (out_on),
        .export_mode (export_mode),
        .gen_hold    (gen_hold),
        .slice_sel   (slice_sel),
        .entropy_vec (entropy_vec),
        .fifo_byte   (fifo_byte),
        .num_valid   (num_valid)
    );

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Edges until num_valid is seen high, counting the first edge after the call as 1
    task automatic wait_pulse(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!num_valid && k < 2000);
    endtask

    // Number of cycles with num_valid high over n edges
    task automatic count_pulses(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (num_valid) hits++;
        end
    endtask

    task automatic t_reset_start();
        int k;
        rst_n = 1'b0; ent_on = 1'b1; out_on = 1'b1;
        export_mode = 1'b0; gen_hold = 1'b0;
        repeat (3) @(negedge clk);
        check_int("R1 num_valid in reset", int'(num_valid), 0);
        rst_n = 1'b1;
        wait_pulse(k);
        check_int("R1 first pulse after reset (native)", k, 731);
        wait_pulse(k);
        check_int("R5 native period", k, 730);
    endtask

    task automatic t_hold_cancel();
        int k, hits;
        repeat (500) @(negedge clk);
        gen_hold = 1'b1;
        count_pulses(800, hits);
        check_int("R2 no pulse while hold kept high", hits, 0);
        gen_hold = 1'b0;
        wait_pulse(k);
        check_int("R3 native release latency", k, 731);
    endtask

    task automatic t_export_release();
        int k;
        gen_hold = 1'b1;
        repeat (5) @(negedge clk);
        export_mode = 1'b1;
        repeat (5) @(negedge clk);
        gen_hold = 1'b0;
        wait_pulse(k);
        check_int("R3 export release latency", k, 81);
        wait_pulse(k);
        check_int("R5 export period", k, 80);
    endtask

    task automatic t_mode_switch();
        int k;
        repeat (30) @(negedge clk);
        export_mode = 1'b0;
        wait_pulse(k);
        check_int("R4 switch 1->0 latency", k, 731);
        repeat (300) @(negedge clk);
        export_mode = 1'b1;
        wait_pulse(k);
        check_int("R4 switch 0->1 latency", k, 81);
    endtask

    task automatic t_pause();
        int k, hits;
        repeat (40) @(negedge clk);
        ent_on = 1'b0;
        count_pulses(50, hits);
        check_int("R6 no pulse while entropy off", hits, 0);
        ent_on = 1'b1;
        wait_pulse(k);
        check_int("R6 resume from held count", k, 40);
    endtask

    task automatic t_gate();
        int k, hits;
        out_on = 1'b0;
        count_pulses(200, hits);
        check_int("R7 no pulse while output off", hits, 0);
        out_on = 1'b1;
        wait_pulse(k);
        check_int("R7 phase kept across gate", k, 40);
    endtask

    function automatic logic [7:0] pat_byte(input int i);
        return 8'(8'hA5 ^ (i * 29));
    endfunction

    task automatic t_slice();
        int bad;
        bad = 0;
        for (int i = 0; i < 16; i++) entropy_vec[i*8 +: 8] = pat_byte(i);
        for (int s = 0; s < 16; s++) begin
            slice_sel = 4'(s);
            #1;
            if (fifo_byte !== pat_byte(s)) begin
                bad++;
                $display("FAIL R8 slice %0d: actual %02h expected %02h", s, fifo_byte, pat_byte(s));
            end
        end
        n_checks++;
        if (bad != 0) n_fails++;
        slice_sel = 4'd15;
        entropy_vec = '0;
        entropy_vec[127:120] = 8'h3C;
        #1;
        check_int("R8 top slice", int'(fifo_byte), 8'h3C);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        slice_sel = 4'd0;
        entropy_vec = '0;
        t_reset_start();
        t_hold_cancel();
        t_export_release();
        t_mode_switch();
        t_pause();
        t_gate();
        t_slice();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule